// File: doc/BRIEF.md
# I2C Master Command and Receive FIFO Front End

This block sits between the register port of an I2C master and its bit engine. Software writes one command register. Each write queues a 9-bit command word: either a byte to send, or a request to read one byte from the bus. The bit engine drains those words through a valid/ready pop port. Bytes the engine receives are pushed into a second FIFO, and software collects them by reading the same command register.

Fill levels of both FIFOs can be read back at any time. Two level-versus-threshold indications tell software when to refill the transmit side and when to drain the receive side. A read-only register reports both FIFO depths minus one, so that driver code can size its bursts. Three single-cycle pulses flag lost accesses:

- a write to a full transmit FIFO,
- a read from an empty receive FIFO,
- an engine push into a full receive FIFO.

A one-bit enable register gates the whole block. While it is clear, both FIFOs are held empty.

Top module: `i2cff_top`

## Requirements
- R1: A write to address 0x10 with bit 8 clear queues the word {0, bits 7:0}. The engine receives queued words in write order on `cmdWord`.
- R2: A write to address 0x10 with bit 8 set queues the read request 0x100. Bits 7:0 of the written value are discarded.
- R3: A read of address 0x10 returns the oldest received byte in bits 7:0, with zeros above, and removes that byte at the clock edge ending the read.
- R4: A write to 0x10 while the transmit FIFO holds its full depth is dropped. `txOverPulse` is high for the one cycle after that write.
- R5: A read of 0x10 while the receive FIFO is empty returns 0 and leaves the level unchanged. `rxUnderPulse` is high for the one cycle after that read.
- R6: An engine push while the receive FIFO is full is dropped and the stored bytes are kept. `rxOverPulse` is high for the one cycle after that push.
- R7: Bit 0 of address 0x6C enables the block, and it resets to 0. While the block is disabled, both FIFO levels drop to 0 on the next edge. While disabled, writes to 0x10 and engine pushes are ignored without any pulse, and `cmdValid` is low.
- R8: `txEmptyFlag` is high exactly when the block is enabled and the transmit level is at or below the transmit threshold held at 0x3C.
- R9: `rxFullFlag` is high exactly when the receive level exceeds the receive threshold held at 0x38. A threshold of 0 raises the flag as soon as one byte is stored.
- R10: The transmit level reads at 0x74 and the receive level reads at 0x78.
- R11: Address 0xF4 reads the transmit depth minus one in bits 23:16 and the receive depth minus one in bits 15:8. All other bits read 0.
- R12: `cmdValid` is high when the block is enabled and the transmit FIFO is not empty. A cycle with both `cmdValid` and `cmdReady` high removes the head word at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; side effects take place at the edge |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from the address |
| cmdValid | output | 1 | Transmit FIFO holds a word for the engine |
| cmdReady | input | 1 | Engine takes the head word |
| cmdWord | output | 9 | Head command word; bit 8 marks a read request |
| rxPushValid | input | 1 | Engine delivers a received byte |
| rxPushData | input | 8 | Received byte |
| txEmptyFlag | output | 1 | Transmit level at or below its threshold |
| rxFullFlag | output | 1 | Receive level above its threshold |
| txOverPulse | output | 1 | A command write was dropped |
| rxUnderPulse | output | 1 | A read found the receive FIFO empty |
| rxOverPulse | output | 1 | An engine push was dropped |

## Verification
The bench builds the block with a depth of 4 on both the transmit and the receive side. With that depth, a handful of register writes or engine pushes reaches the full condition, so the dropped-write, dropped-push and over-pulse paths are all exercised. The same small depths make it possible to step the receive threshold across every possible level. They also give the parameter register a non-default value of 0x00030300 to check.

// File: rtl/i2cff_pkg.sv
package i2cff_pkg;

  // Register byte addresses
  localparam logic [7:0] ADDR_DATA   = 8'h10;
  localparam logic [7:0] ADDR_RXTHR  = 8'h38;
  localparam logic [7:0] ADDR_TXTHR  = 8'h3C;
  localparam logic [7:0] ADDR_ENABLE = 8'h6C;
  localparam logic [7:0] ADDR_TXLVL  = 8'h74;
  localparam logic [7:0] ADDR_RXLVL  = 8'h78;
  localparam logic [7:0] ADDR_PARAM  = 8'hF4;

  localparam logic [8:0] READ_REQUEST = 9'h100;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrobes_t;

endpackage

// File: rtl/i2cff_fifo.sv
module i2cff_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr;
  logic [PW-1:0]    rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];

  // R4 / R6: control must never push into a full store
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    push |-> level < LW'(DEPTH));

  // R3 / R12: control must never pop an empty store
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> level != '0);

  // R10: outside a flush the level moves by at most one per cycle
  p_level_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> (level == $past(level)) || (level == $past(level) + 1'b1) ||
               (level == $past(level) - 1'b1));

endmodule

// File: rtl/i2cff_datapath.sv
module i2cff_datapath
  import i2cff_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [8:0]       txWord,
  input  logic [7:0]       rxByte,
  output logic [8:0]       cmdWord,
  output logic [7:0]       rxHead,
  output logic [TX_LW-1:0] txLevel,
  output logic [RX_LW-1:0] rxLevel
);

  i2cff_fifo #(.WIDTH(9), .DEPTH(TX_DEPTH)) i_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.txPush),
    .pushData (txWord),
    .pop      (strobes.txPop),
    .headData (cmdWord),
    .level    (txLevel)
  );

  i2cff_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) i_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.rxPush),
    .pushData (rxByte),
    .pop      (strobes.rxPop),
    .headData (rxHead),
    .level    (rxLevel)
  );

endmodule

// File: rtl/i2cff_control.sv
module i2cff_control
  import i2cff_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             cmdReady,
  output logic             cmdValid,
  input  logic             rxPushValid,
  input  logic [TX_LW-1:0] txLevel,
  input  logic [RX_LW-1:0] rxLevel,
  input  logic [7:0]       rxHead,
  output fifoStrobes_t     strobes,
  output logic [8:0]       txWord,
  output logic             txEmptyFlag,
  output logic             rxFullFlag,
  output logic             txOverPulse,
  output logic             rxUnderPulse,
  output logic             rxOverPulse
);

  localparam logic [7:0] TX_DEPTH_M1 = 8'(TX_DEPTH - 1);
  localparam logic [7:0] RX_DEPTH_M1 = 8'(RX_DEPTH - 1);

  logic       enabled;
  logic [7:0] txThr;
  logic [7:0] rxThr;
  logic       dataHit;
  logic       txFull;
  logic       rxFull;
  logic       txEmpty;
  logic       rxEmpty;
  logic       unusedWrBits;

  assign unusedWrBits = ^regWrData[31:9];

  assign dataHit = (regAddr == ADDR_DATA);
  assign txFull  = (txLevel == TX_LW'(TX_DEPTH));
  assign rxFull  = (rxLevel == RX_LW'(RX_DEPTH));
  assign txEmpty = (txLevel == '0);
  assign rxEmpty = (rxLevel == '0);

  // Command word: read requests carry no data
  assign txWord = regWrData[8] ? READ_REQUEST : {1'b0, regWrData[7:0]};

  assign cmdValid = enabled && !txEmpty;

  always_comb begin
    strobes.txPush = enabled && regWrEn && dataHit && !txFull;
    strobes.rxPop  = enabled && regRdEn && dataHit && !rxEmpty;
    strobes.txPop  = cmdValid && cmdReady;
    strobes.rxPush = enabled && rxPushValid && !rxFull;
    strobes.flush  = !enabled;
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabled <= 1'b0;
      txThr   <= '0;
      rxThr   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_ENABLE: enabled <= regWrData[0];
        ADDR_TXTHR:  txThr   <= regWrData[7:0];
        ADDR_RXTHR:  rxThr   <= regWrData[7:0];
        default: ;
      endcase
    end
  end

  // Lost-access pulses, one cycle after the offending access
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOverPulse  <= 1'b0;
      rxUnderPulse <= 1'b0;
      rxOverPulse  <= 1'b0;
    end else begin
      txOverPulse  <= enabled && regWrEn && dataHit && txFull;
      rxUnderPulse <= enabled && regRdEn && dataHit && rxEmpty;
      rxOverPulse  <= enabled && rxPushValid && rxFull;
    end
  end

  // Threshold indications
  assign txEmptyFlag = enabled && (16'(txLevel) <= 16'(txThr));
  assign rxFullFlag  = (16'(rxLevel) > 16'(rxThr));

  // Register read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_DATA:   regRdData = rxEmpty ? 32'h0 : {24'h0, rxHead};
      ADDR_RXTHR:  regRdData = {24'h0, rxThr};
      ADDR_TXTHR:  regRdData = {24'h0, txThr};
      ADDR_ENABLE: regRdData = {31'h0, enabled};
      ADDR_TXLVL:  regRdData = 32'(txLevel);
      ADDR_RXLVL:  regRdData = 32'(rxLevel);
      ADDR_PARAM:  regRdData = {8'h0, TX_DEPTH_M1, RX_DEPTH_M1, 8'h0};
      default:     regRdData = '0;
    endcase
  end

  // R7: a disabled cycle leaves both stores empty after the next edge
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> (txLevel == '0) && (rxLevel == '0));

  // R4: an over pulse only follows a cycle with the transmit store full
  p_tx_over_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    txOverPulse |-> $past(txLevel) == TX_LW'(TX_DEPTH));

  // R5: an under pulse only follows a cycle with nothing received
  p_rx_under_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderPulse |-> $past(rxLevel) == '0);

  // R6: a dropped push keeps the receive store full
  p_rx_over_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxOverPulse |-> $past(rxLevel) == RX_LW'(RX_DEPTH));

endmodule

// File: rtl/i2cff_top.sv
module i2cff_top
  import i2cff_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic [8:0]  cmdWord,
  input  logic        rxPushValid,
  input  logic [7:0]  rxPushData,
  output logic        txEmptyFlag,
  output logic        rxFullFlag,
  output logic        txOverPulse,
  output logic        rxUnderPulse,
  output logic        rxOverPulse
);

  localparam int TX_LW = $clog2(TX_DEPTH + 1);
  localparam int RX_LW = $clog2(RX_DEPTH + 1);

  fifoStrobes_t     strobes;
  logic [8:0]       txWord;
  logic [7:0]       rxHead;
  logic [TX_LW-1:0] txLevel;
  logic [RX_LW-1:0] rxLevel;

  i2cff_control #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .cmdReady     (cmdReady),
    .cmdValid     (cmdValid),
    .rxPushValid  (rxPushValid),
    .txLevel      (txLevel),
    .rxLevel      (rxLevel),
    .rxHead       (rxHead),
    .strobes      (strobes),
    .txWord       (txWord),
    .txEmptyFlag  (txEmptyFlag),
    .rxFullFlag   (rxFullFlag),
    .txOverPulse  (txOverPulse),
    .rxUnderPulse (rxUnderPulse),
    .rxOverPulse  (rxOverPulse)
  );

  i2cff_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txWord  (txWord),
    .rxByte  (rxPushData),
    .cmdWord (cmdWord),
    .rxHead  (rxHead),
    .txLevel (txLevel),
    .rxLevel (rxLevel)
  );

endmodule

// File: tb/test_i2cff_top.sv
module test_i2cff_top;

  localparam int TXD = 4;
  localparam int RXD = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [8:0]  cmdWord;
  logic        rxPushValid = 1'b0;
  logic [7:0]  rxPushData = '0;
  logic        txEmptyFlag, rxFullFlag, txOverPulse, rxUnderPulse, rxOverPulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  i2cff_top #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_i2cff_top (
    .clk, .rstN, .regWrEn, .regRdEn, .regAddr, .regWrData, .regRdData,
    .cmdValid, .cmdReady, .cmdWord, .rxPushValid, .rxPushData,
    .txEmptyFlag, .rxFullFlag, .txOverPulse, .rxUnderPulse, .rxOverPulse
  );

  typedef struct packed {
    logic        isRead;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h6C, 32'h0000_0001},
    '{1'b0, 8'h3C, 32'h0000_0001},
    '{1'b0, 8'h38, 32'h0000_0000},
    '{1'b0, 8'h10, 32'h0000_00A5},
    '{1'b0, 8'h10, 32'h0000_01FF},
    '{1'b1, 8'h74, 32'h0000_0002},
    '{1'b1, 8'h78, 32'h0000_0000},
    '{1'b1, 8'h3C, 32'h0000_0001},
    '{1'b1, 8'hF4, 32'h0003_0300},
    '{1'b1, 8'h6C, 32'h0000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic engPop(input string tag, input logic [8:0] exp);
    @(negedge clk);
    chk(tag, 32'(cmdValid), 32'h1);
    chk(tag, 32'(cmdWord), 32'(exp));
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] d);
    @(negedge clk);
    rxPushValid = 1'b1; rxPushData = d;
    @(negedge clk);
    rxPushValid = 1'b0;
  endtask

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h74, 8'h78: return "R10";
      8'hF4:        return "R11";
      8'h6C:        return "R7";
      default:      return "R8";
    endcase
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R7, R11, R12)
    @(negedge clk);
    chk("R12 reset cmdValid", 32'(cmdValid), 32'h0);
    chk("R8 reset txEmptyFlag", 32'(txEmptyFlag), 32'h0);
    regRead(8'h6C, v); chk("R7 reset enable", v, 32'h0);
    regRead(8'hF4, v); chk("R11 param", v, 32'h0003_0300);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRead) begin
        regRead(VECS[i].addr, v);
        chk(tagFor(VECS[i].addr), v, VECS[i].data);
      end else begin
        regWrite(VECS[i].addr, VECS[i].data);
      end
    end

    // Threshold 1, level 2: not empty enough (R8)
    chk("R8 level above thr", 32'(txEmptyFlag), 32'h0);
    engPop("R1 byte word", 9'h0A5);
    chk("R8 level at thr", 32'(txEmptyFlag), 32'h1);
    engPop("R2 read request", 9'h100);
    chk("R12 drained", 32'(cmdValid), 32'h0);

    // Fill transmit side, overflow (R4)
    for (int k = 1; k <= TXD; k++) begin
      regWrite(8'h10, 32'(k));
      chk("R4 no pulse below full", 32'(txOverPulse), 32'h0);
    end
    regWrite(8'h10, 32'h0000_0077);
    chk("R4 over pulse", 32'(txOverPulse), 32'h1);
    regRead(8'h74, v); chk("R4 level held", v, 32'(TXD));
    for (int k = 1; k <= TXD; k++) engPop("R1 order", 9'(k));

    // Receive side thresholds (R9)
    chk("R9 empty", 32'(rxFullFlag), 32'h0);
    engPush(8'h11);
    chk("R9 thr0 one byte", 32'(rxFullFlag), 32'h1);
    regWrite(8'h38, 32'h2);
    chk("R9 thr2 level1", 32'(rxFullFlag), 32'h0);
    engPush(8'h22);
    engPush(8'h33);
    chk("R9 thr2 level3", 32'(rxFullFlag), 32'h1);
    engPush(8'h44);
    chk("R6 no pulse at fill", 32'(rxOverPulse), 32'h0);
    engPush(8'h55);
    chk("R6 over pulse", 32'(rxOverPulse), 32'h1);
    regRead(8'h78, v); chk("R6 level held", v, 32'(RXD));
    regRead(8'h10, v); chk("R3 pop 1", v, 32'h11);
    regRead(8'h10, v); chk("R3 pop 2", v, 32'h22);
    regRead(8'h10, v); chk("R3 pop 3", v, 32'h33);
    regRead(8'h10, v); chk("R6 last kept", v, 32'h44);
    chk("R5 no under pulse", 32'(rxUnderPulse), 32'h0);
    regRead(8'h10, v); chk("R5 empty read", v, 32'h0);
    chk("R5 under pulse", 32'(rxUnderPulse), 32'h1);
    regRead(8'h78, v); chk("R5 level", v, 32'h0);

    // Disable flushes and ignores (R7)
    regWrite(8'h10, 32'h0000_0001);
    regWrite(8'h10, 32'h0000_0002);
    engPush(8'h66);
    regWrite(8'h6C, 32'h0);
    regRead(8'h74, v); chk("R7 tx flushed", v, 32'h0);
    regRead(8'h78, v); chk("R7 rx flushed", v, 32'h0);
    regWrite(8'h10, 32'h0000_0009);
    chk("R7 no over pulse", 32'(txOverPulse), 32'h0);
    engPush(8'h99);
    chk("R7 cmdValid low", 32'(cmdValid), 32'h0);
    regRead(8'h74, v); chk("R7 tx write ignored", v, 32'h0);
    regRead(8'h78, v); chk("R7 rx push ignored", v, 32'h0);
    regWrite(8'h6C, 32'h1);
    regWrite(8'h10, 32'h0000_01C3);
    engPop("R2 data bits ignored", 9'h100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule